// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus master and a word-addressed peripheral or SRAM region. A large alias window is laid over the target window, and each word of the alias window stands for a single bit of the target window. Storing to an alias word changes that one bit of the target word. The bridge does this as an indivisible read followed by a write. Loading from an alias word returns the selected bit in bit 0, with every other bit zero.

Any address outside the alias window, including the target window itself, is handed to the downstream side unchanged as one transaction. Both sides use a valid/ready handshake, and a transfer completes in the cycle where both are high. The upstream master holds its request fields steady until it sees ready. Read data on either side is valid in the cycle that ready is high.

The alias window starts at 0x4200_0000 and the target window starts at 0x4000_0000. For an alias address A, the target byte offset is ((A − alias base) >> 5) with the two low bits cleared. The bit number is ((A − alias base) >> 2) mod 32. As a result, target 0x4002_0014 bit 5 is reached through alias 0x4240_0294.

Top module: `bitband_bridge`

## Requirements
- R1: An alias access to address A targets downstream address 0x4000_0000 + (((A − 0x4200_0000) >> 5) & ~3), bit ((A − 0x4200_0000) >> 2) & 31. Alias 0x4240_0294 maps to 0x4002_0014, bit 5. The alias window spans 0x4200_0000 to 0x43FF_FFFF.
- R2: An alias write with up_wdata bit 0 equal to 1 sets the mapped bit and leaves the other 31 bits of the target word as they were read.
- R3: An alias write with up_wdata bit 0 equal to 0 clears the mapped bit. Bits 31:1 of up_wdata have no effect on the stored word.
- R4: An alias read returns the mapped bit in up_rdata bit 0 and zeros in bits 31:1. It causes exactly one downstream read and no downstream write.
- R5: An alias write causes exactly one downstream read of the target word, followed by exactly one downstream write to the same address. up_ready stays low from acceptance until both have completed.
- R6: Any address outside the alias window is forwarded once, with address, direction and write data unmodified, and a read returns the downstream data unchanged.
- R7: up_ready is high for exactly one cycle per request, after the downstream side has finished. While dn_valid is high and dn_ready is low, dn_addr, dn_write and dn_wdata hold steady.
- R8: While reset is asserted, up_ready and dn_valid are low.
- R9: Address bits 1:0 of an alias access have no effect on the target address or on the bit selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Master request valid |
| up_ready | output | 1 | Request complete, single-cycle pulse |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Byte address of the request |
| up_wdata | input | 32 | Write data (bit 0 only for alias writes) |
| up_rdata | output | 32 | Read data, valid while up_ready is high |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream transfer complete |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ready |

## Verification
The assertions rely on the master keeping up_valid, up_addr, up_write and up_wdata steady from the start of a request until the cycle after up_ready. They also rely on the slave presenting read data in the same cycle it raises dn_ready. The checker depends on these because it computes the expected target address and merged word from the live request, and from the word it saw coming back. The bench master drives a request at a falling edge, waits for up_ready, and releases the request only one falling edge after the handshake. The bench slave registers its ready and data together, with a programmable number of wait cycles.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // Sequencer states of the bridge
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD,
    ST_FETCH,
    ST_STORE,
    ST_RESP
  } seq_state_e;

  // Classification of an accepted request
  typedef enum logic [1:0] {
    K_FWD,
    K_ALIAS_RD,
    K_ALIAS_WR
  } op_kind_e;

endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bb_addr_map.sv
// Decodes a word address into alias-window membership, target word address
// and bit index.
module bb_addr_map #(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h4000_0000,
  parameter int                REGION_LOG2 = 20,
  localparam int               LANE_W      = $clog2(DATA_W / 8),
  localparam int               BIT_W       = $clog2(DATA_W)
) (
  input  logic [ADDR_W-LANE_W-1:0] waddr,
  output logic                     is_alias,
  output logic [ADDR_W-1:0]        tgt_addr,
  output logic [BIT_W-1:0]         bit_sel
);

  // Each target byte expands to 8 alias words of 2^LANE_W bytes
  localparam int ALIAS_LOG2 = REGION_LOG2 + 3 + LANE_W;
  localparam int IDX_W      = REGION_LOG2 - LANE_W;

  logic [ADDR_W-1:0] word_off;

  always_comb begin
    is_alias = (waddr[ADDR_W-LANE_W-1:ALIAS_LOG2-LANE_W] ==
                ALIAS_BASE[ADDR_W-1:ALIAS_LOG2]);
    word_off = '0;
    word_off[REGION_LOG2-1:LANE_W] = waddr[BIT_W+IDX_W-1:BIT_W];
    tgt_addr = TARGET_BASE + word_off;
    bit_sel  = waddr[BIT_W-1:0];
  end

endmodule

// File: rtl/bb_bit_merge.sv
// Extracts one bit of a word and produces the word with that bit replaced.
module bb_bit_merge #(
  parameter int  DATA_W = 32,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic              new_bit,
  output logic [DATA_W-1:0] merged,
  output logic              picked
);

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign merged[g] = (bit_sel == BIT_W'(g)) ? new_bit : word[g];
  end

  assign picked = word[bit_sel];

endmodule

// File: rtl/bb_seq.sv
// Request sequencer: forwards, or performs a locked fetch/store pair.
module bb_seq
  import bb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_valid,
  input  op_kind_e   kind_live,
  input  op_kind_e   kind_q,
  input  logic       dn_ready,
  output seq_state_e state,
  output logic       load,
  output logic       dn_valid,
  output logic       up_ready
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (up_valid) begin
          state_d = (kind_live == K_FWD) ? ST_FWD : ST_FETCH;
        end
      end
      ST_FWD: begin
        if (dn_ready) state_d = ST_RESP;
      end
      ST_FETCH: begin
        if (dn_ready) state_d = (kind_q == K_ALIAS_WR) ? ST_STORE : ST_RESP;
      end
      ST_STORE: begin
        if (dn_ready) state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state    = state_q;
  assign load     = (state_q == ST_IDLE) && up_valid;
  assign dn_valid = (state_q == ST_FWD) || (state_q == ST_FETCH) ||
                    (state_q == ST_STORE);
  assign up_ready = (state_q == ST_RESP);

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h4000_0000,
  parameter int                REGION_LOG2 = 20,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata
);

  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam int BIT_W  = $clog2(DATA_W);

  logic       rst_n_int;
  seq_state_e state;
  logic       load;
  logic       is_alias;
  op_kind_e   kind_live;

  logic [ADDR_W-1:0] map_tgt;
  logic [BIT_W-1:0]  map_bit;

  // Captured request and working registers
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              write_q, write_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  op_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              reg_en;

  logic [DATA_W-1:0] merge_src;
  logic [DATA_W-1:0] merged;
  logic              picked;
  logic              is_fwd;

  bb_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_int)
  );

  bb_addr_map #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ALIAS_BASE (ALIAS_BASE),
    .TARGET_BASE(TARGET_BASE),
    .REGION_LOG2(REGION_LOG2)
  ) u_map (
    .waddr   (up_addr[ADDR_W-1:LANE_W]),
    .is_alias(is_alias),
    .tgt_addr(map_tgt),
    .bit_sel (map_bit)
  );

  assign kind_live = !is_alias ? K_FWD : (up_write ? K_ALIAS_WR : K_ALIAS_RD);

  bb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .up_valid (up_valid),
    .kind_live(kind_live),
    .kind_q   (kind_q),
    .dn_ready (dn_ready),
    .state    (state),
    .load     (load),
    .dn_valid (dn_valid),
    .up_ready (up_ready)
  );

  // During the fetch the returned word is inspected directly; afterwards
  // the held copy feeds the merge for the store.
  assign merge_src = (state == ST_FETCH) ? dn_rdata : word_q;

  bb_bit_merge #(
    .DATA_W(DATA_W)
  ) u_merge (
    .word   (merge_src),
    .bit_sel(bit_q),
    .new_bit(wdata_q[0]),
    .merged (merged),
    .picked (picked)
  );

  // Next-state of the datapath registers
  always_comb begin
    addr_d  = addr_q;
    write_d = write_q;
    wdata_d = wdata_q;
    kind_d  = kind_q;
    tgt_d   = tgt_q;
    bit_d   = bit_q;
    word_d  = word_q;
    rdata_d = rdata_q;
    if (load) begin
      addr_d  = up_addr;
      write_d = up_write;
      wdata_d = up_wdata;
      kind_d  = kind_live;
      tgt_d   = map_tgt;
      bit_d   = map_bit;
      rdata_d = '0;
    end
    if ((state == ST_FWD) && dn_ready && !write_q) begin
      rdata_d = dn_rdata;
    end
    if ((state == ST_FETCH) && dn_ready) begin
      word_d  = dn_rdata;
      rdata_d = {{(DATA_W-1){1'b0}}, picked};
    end
  end

  assign reg_en = load || (dn_valid && dn_ready);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      kind_q  <= K_FWD;
      tgt_q   <= '0;
      bit_q   <= '0;
      word_q  <= '0;
      rdata_q <= '0;
    end else if (reg_en) begin
      addr_q  <= addr_d;
      write_q <= write_d;
      wdata_q <= wdata_d;
      kind_q  <= kind_d;
      tgt_q   <= tgt_d;
      bit_q   <= bit_d;
      word_q  <= word_d;
      rdata_q <= rdata_d;
    end
  end

  assign is_fwd   = (kind_q == K_FWD);
  assign dn_addr  = is_fwd ? addr_q : tgt_q;
  assign dn_write = is_fwd ? write_q : (state == ST_STORE);
  assign dn_wdata = is_fwd ? wdata_q : ((state == ST_STORE) ? merged : '0);
  assign up_rdata = rdata_q;

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h4000_0000,
  parameter int                REGION_LOG2 = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic              up_write,
  input logic [ADDR_W-1:0] up_addr,
  input logic [DATA_W-1:0] up_wdata,
  input logic [DATA_W-1:0] up_rdata,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dn_write,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [DATA_W-1:0] dn_wdata,
  input logic [DATA_W-1:0] dn_rdata
);

  localparam int LANE_W     = $clog2(DATA_W / 8);
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int ALIAS_LOG2 = REGION_LOG2 + 3 + LANE_W;

  logic [ADDR_W-1:0] delta;
  logic              in_alias;
  logic [ADDR_W-1:0] exp_tgt;
  logic [BIT_W-1:0]  exp_bit;
  logic [DATA_W-1:0] bit_mask;
  logic              seen_rd;
  logic [DATA_W-1:0] rd_q;

  // Reference translation by subtraction and shifting
  always_comb begin
    delta    = up_addr - ALIAS_BASE;
    in_alias = ((delta >> ALIAS_LOG2) == '0);
    exp_tgt  = TARGET_BASE +
               ((delta >> (3 + LANE_W)) & {{(ADDR_W-LANE_W){1'b1}}, {LANE_W{1'b0}}});
    exp_bit  = BIT_W'(delta >> LANE_W);
    bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << exp_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_rd <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (up_ready) begin
        seen_rd <= 1'b0;
      end else if (dn_valid && dn_ready && !dn_write) begin
        seen_rd <= 1'b1;
        rd_q    <= dn_rdata;
      end
    end
  end

  // R8: idle outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r8: assert (!up_ready && !dn_valid)
        else $error("reset: outputs not idle");
    end
  end

  p_alias_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && in_alias && dn_valid) |-> (dn_addr == exp_tgt));

  p_merge_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && in_alias && dn_valid && dn_write) |->
      (((dn_wdata ^ rd_q) & ~bit_mask) == '0));

  p_merge_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && in_alias && dn_valid && dn_write) |->
      (((dn_wdata & bit_mask) != '0) == up_wdata[0]));

  p_alias_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready && up_valid && !up_write && in_alias) |->
      (up_rdata[DATA_W-1:1] == '0));

  p_alias_rd_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_write && in_alias) |-> !(dn_valid && dn_write));

  p_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && in_alias && dn_valid && dn_write) |-> seen_rd);

  p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !up_ready);

  p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !in_alias && dn_valid) |->
      (dn_addr == up_addr && dn_write == up_write && dn_wdata == up_wdata));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);

  p_dn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=>
      (dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)));

endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .ALIAS_BASE (ALIAS_BASE),
  .TARGET_BASE(TARGET_BASE),
  .REGION_LOG2(REGION_LOG2)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .up_valid(up_valid),
  .up_ready(up_ready),
  .up_write(up_write),
  .up_addr (up_addr),
  .up_wdata(up_wdata),
  .up_rdata(up_rdata),
  .dn_valid(dn_valid),
  .dn_ready(dn_ready),
  .dn_write(dn_write),
  .dn_addr (dn_addr),
  .dn_wdata(dn_wdata),
  .dn_rdata(dn_rdata)
);

// File: tb/bitband_bridge_tb.sv
`timescale 1ns/1ps
module bitband_bridge_tb;

  localparam logic [31:0] AB = 32'h4200_0000;
  localparam logic [31:0] TB = 32'h4000_0000;

  logic        clk, rst_n;
  logic        up_valid, up_ready, up_write;
  logic [31:0] up_addr, up_wdata, up_rdata;
  logic        dn_valid, dn_ready, dn_write;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;

  int n_vec = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  bitband_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  // Downstream slave: 16-word memory indexed by address bits 5:2
  logic [31:0] mem [16];
  int          s_lat;
  int          s_cnt;
  logic        s_ready;
  logic [31:0] s_rdata;
  int          n_rd, n_wr;
  logic [7:0]  hist;
  logic [31:0] last_wr_addr, last_wr_data, last_rd_addr;

  assign dn_ready = s_ready;
  assign dn_rdata = s_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      s_cnt <= 0; s_ready <= 1'b0; s_rdata <= '0;
      n_rd <= 0; n_wr <= 0; hist <= '0;
      last_wr_addr <= '0; last_wr_data <= '0; last_rd_addr <= '0;
    end else if (s_ready) begin
      s_ready <= 1'b0;
      s_cnt   <= 0;
    end else if (dn_valid) begin
      if (s_cnt >= s_lat) begin
        s_ready <= 1'b1;
        hist    <= {hist[6:0], dn_write};
        if (dn_write) begin
          mem[dn_addr[5:2]] <= dn_wdata;
          n_wr <= n_wr + 1;
          last_wr_addr <= dn_addr;
          last_wr_data <= dn_wdata;
        end else begin
          s_rdata <= mem[dn_addr[5:2]];
          n_rd <= n_rd + 1;
          last_rd_addr <= dn_addr;
        end
      end else begin
        s_cnt <= s_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] alias_of(logic [31:0] tgt, int b);
    return AB + ((tgt - TB) << 5) + (32'(b) << 2);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic ready_after;

  task automatic access(input logic wr, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] rd);
    int w = 0;
    up_write = wr; up_addr = a; up_wdata = d; up_valid = 1'b1;
    @(negedge clk);
    while (!up_ready && w < 1000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 1000) begin
      n_vec++; n_bad++;
      $display("FAIL R7 response actual=none expected=up_ready");
    end
    rd = up_rdata;
    @(negedge clk);
    ready_after = up_ready;
    up_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 up_ready in reset", 32'(up_ready), 32'd0);
    chk("R8 dn_valid in reset", 32'(dn_valid), 32'd0);
  endtask

  // Worked example: target 0x4002_0014 bit 5 via alias 0x4240_0294
  task automatic t_example();
    logic [31:0] r;
    int rd0, wr0;
    access(1'b1, 32'h4002_0014, 32'hA5A5_0000, r);
    rd0 = n_rd; wr0 = n_wr;
    access(1'b1, 32'h4240_0294, 32'h0000_0001, r);
    chk("R1 write address", last_wr_addr, 32'h4002_0014);
    chk("R1 read address", last_rd_addr, 32'h4002_0014);
    chk("R5 one read", 32'(n_rd - rd0), 32'd1);
    chk("R5 one write", 32'(n_wr - wr0), 32'd1);
    chk("R5 read then write", 32'(hist[1:0]), 32'd1);
    access(1'b0, 32'h4002_0014, 32'h0, r);
    chk("R2 bit 5 set", r, 32'hA5A5_0020);
  endtask

  task automatic t_clear();
    logic [31:0] r;
    access(1'b1, 32'h4240_0294, 32'hFFFF_FFFE, r);
    access(1'b0, 32'h4002_0014, 32'h0, r);
    chk("R3 bit 5 cleared", r, 32'hA5A5_0000);
    access(1'b1, alias_of(32'h4002_0014, 16), 32'hFFFF_FFFE, r);
    access(1'b0, 32'h4002_0014, 32'h0, r);
    chk("R3 bit 16 cleared", r, 32'hA5A4_0000);
    access(1'b1, alias_of(32'h4002_0014, 16), 32'h0000_0003, r);
    access(1'b0, 32'h4002_0014, 32'h0, r);
    chk("R3 upper wdata ignored", r, 32'hA5A5_0000);
  endtask

  task automatic t_alias_read();
    logic [31:0] r;
    int rd0, wr0;
    rd0 = n_rd; wr0 = n_wr;
    access(1'b0, alias_of(32'h4002_0014, 16), 32'hFFFF_FFFF, r);
    chk("R4 bit 16 reads one", r, 32'h0000_0001);
    chk("R4 single read", 32'(n_rd - rd0), 32'd1);
    chk("R4 no write", 32'(n_wr - wr0), 32'd0);
    access(1'b0, 32'h4240_0294, 32'h0, r);
    chk("R4 bit 5 reads zero", r, 32'h0000_0000);
    access(1'b0, alias_of(32'h4002_0014, 31), 32'h0, r);
    chk("R4 bit 31 reads one", r, 32'h0000_0001);
    access(1'b0, 32'h4002_0014, 32'h0, r);
    chk("R4 word untouched", r, 32'hA5A5_0000);
  endtask

  task automatic t_sweep();
    logic [31:0] r;
    access(1'b1, TB, 32'h0, r);
    access(1'b1, alias_of(TB, 0), 32'h1, r);
    chk("R1 lowest word address", last_wr_addr, TB);
    access(1'b0, TB, 32'h0, r);
    chk("R2 bit 0 set", r, 32'h0000_0001);
    access(1'b1, TB + 32'h8, 32'hFFFF_FFFF, r);
    access(1'b1, alias_of(TB + 32'h8, 13), 32'h0, r);
    access(1'b0, TB + 32'h8, 32'h0, r);
    chk("R3 bit 13 cleared", r, 32'hFFFF_DFFF);
    access(1'b1, TB + 32'h000F_FFFC, 32'h1234_5678, r);
    access(1'b1, 32'h43FF_FFFC, 32'h1, r);
    chk("R1 top of window address", last_wr_addr, TB + 32'h000F_FFFC);
    access(1'b0, TB + 32'h000F_FFFC, 32'h0, r);
    chk("R2 bit 31 set", r, 32'h9234_5678);
  endtask

  task automatic t_passthru();
    logic [31:0] r;
    int rd0, wr0;
    rd0 = n_rd; wr0 = n_wr;
    access(1'b1, 32'h1234_5670, 32'hCAFE_F00D, r);
    chk("R6 one write", 32'(n_wr - wr0), 32'd1);
    chk("R6 no read", 32'(n_rd - rd0), 32'd0);
    chk("R6 address kept", last_wr_addr, 32'h1234_5670);
    chk("R6 data kept", last_wr_data, 32'hCAFE_F00D);
    access(1'b0, 32'h1234_5670, 32'h0, r);
    chk("R6 read data", r, 32'hCAFE_F00D);
    access(1'b0, 32'h41FF_FFFC, 32'h0, r);
    chk("R6 below window address", last_rd_addr, 32'h41FF_FFFC);
    chk("R6 below window data", r, 32'h9234_5678);
    access(1'b1, 32'h4400_0000, 32'h5555_AAAA, r);
    chk("R6 above window address", last_wr_addr, 32'h4400_0000);
    chk("R6 above window data", last_wr_data, 32'h5555_AAAA);
  endtask

  task automatic t_low_bits();
    logic [31:0] r;
    access(1'b1, 32'h4240_0294 + 32'd3, 32'h1, r);
    chk("R9 address with low bits", last_wr_addr, 32'h4002_0014);
    access(1'b0, 32'h4002_0014, 32'h0, r);
    chk("R9 bit 5 set", r, 32'hA5A5_0020);
    access(1'b0, 32'h4240_0294 + 32'd1, 32'h0, r);
    chk("R9 read with low bits", r, 32'h0000_0001);
  endtask

  task automatic t_latency();
    logic [31:0] r;
    s_lat = 3;
    access(1'b1, alias_of(32'h4002_0014, 7), 32'h1, r);
    chk("R7 ready single pulse", 32'(ready_after), 32'd0);
    access(1'b0, 32'h4002_0014, 32'h0, r);
    chk("R7 slow slave word", r, 32'hA5A5_00A0);
    chk("R7 ready single pulse fwd", 32'(ready_after), 32'd0);
    s_lat = 0;
    access(1'b0, alias_of(32'h4002_0014, 7), 32'h0, r);
    chk("R7 fast slave bit", r, 32'h0000_0001);
    chk("R7 ready single pulse fast", 32'(ready_after), 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s_lat = 0;
    up_valid = 1'b0; up_write = 1'b0; up_addr = '0; up_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_example();
    t_clear();
    t_alias_read();
    t_sweep();
    t_passthru();
    t_low_bits();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule